// File: doc/BRIEF.md
# Rotating Idle Core Reservation Arbiter

This block lets a core hand a wake-up action to some other core that is idle in host context. Each core can raise a request carrying a nonzero action code. The block picks a target core and reserves it in the same clock edge. A target qualifies when its host-context input is high and its action register is empty. The reservation stores the action code in the target's action register and marks the target as owned.

The search is rotational. It starts at the core just above the requester, wraps through zero and stops just below the requester, so a core never reserves itself. When several cores request in the same cycle, a fixed-priority front end accepts one of them. The others keep their request asserted and are served in later cycles.

When the target finishes its work, it pulses its completion input. Its ownership mark is dropped first, and its action register is cleared one cycle after that. Only then can the core be reserved again.

Top module: `core_resv_arbiter`

## Requirements
- R1: After reset every action register reads zero, every ownership flag is low, and no grant is reported.
- R2: For requester R, the chosen target is the first qualifying core in the order R+1, R+2, ..., N-1, 0, 1, ..., R-1.
- R3: The requester's own index is never reported as the target, even when the requester itself qualifies.
- R4: A core qualifies only when its host-context input is high and its action register is zero. A core that is still being cleared does not qualify.
- R5: On a successful search, at the next rising edge the request's action code is written into the target's action register and the target's ownership flag is set. In that same cycle the grant outputs show valid=1, found=1, the target index and the requester index.
- R6: When no core qualifies, the grant shows valid=1 and found=0 with an index of all ones, and no action register or ownership flag changes.
- R7: A request whose action code is zero is not accepted, and it produces no grant.
- R8: Of the simultaneous requests with nonzero action, only the lowest-numbered requester is accepted. The accept vector, which reacts in the same cycle, is one-hot or zero.
- R9: A completion pulse on an owned core clears its ownership flag at the next edge and clears its action register at the edge after that.
- R10: A completion pulse on a core that is not owned changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inHost | input | NUM_CORES | Per-core flag that the core is in host context |
| reqValid | input | NUM_CORES | Per-requester request strobe |
| reqAction | input | NUM_CORES*ACT_W | Action code for each requester, core i in bits [i*ACT_W +: ACT_W] |
| doneValid | input | NUM_CORES | Per-target completion pulse |
| reqAccept | output | NUM_CORES | Combinational one-hot flag marking the requester served this cycle |
| grantValid | output | 1 | A request was processed at the last edge |
| grantFound | output | 1 | A target was reserved |
| grantIdx | output | IDX_W | Reserved target index, all ones when none was found |
| grantReq | output | IDX_W | Index of the requester that was served |
| actionOut | output | NUM_CORES*ACT_W | Current action register of each core |
| ownerValid | output | NUM_CORES | Per-core ownership flag |

## Verification
A stale or corrupted action register shows up in two ways at the next request whose search passes that core. Either the core is skipped when it should have been chosen, or it is granted twice, and the wrong grant index appears one cycle after the request. A fault in the wrap arithmetic shows as the requester's own index, or as an index below the requester being chosen while a higher one was free. A fault in the clearing sequence shows on actionOut and ownerValid within two cycles of a completion pulse.

// File: rtl/core_resv_pkg.sv
package core_resv_pkg;

  // strobes from the search control to the register datapath
  typedef struct packed {
    logic reserve;   // write the winning action into the chosen core
    logic anyReq;    // a request was accepted this cycle
  } resvStrb_t;

endpackage

// File: rtl/core_resv_ctrl.sv
module core_resv_ctrl
  import core_resv_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int ACT_W     = 4,
  parameter int IDX_W     = $clog2(NUM_CORES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CORES-1:0]       reqValid,
  input  logic [NUM_CORES*ACT_W-1:0] reqAction,
  input  logic [NUM_CORES-1:0]       eligible,
  output logic [NUM_CORES-1:0]       reqAccept,
  output resvStrb_t                  strb,
  output logic [IDX_W-1:0]           resvIdx,
  output logic [ACT_W-1:0]           resvAct,
  output logic                       grantValid,
  output logic                       grantFound,
  output logic [IDX_W-1:0]           grantIdx,
  output logic [IDX_W-1:0]           grantReq
);

  logic [IDX_W-1:0] winIdx;
  logic             winFound;
  logic [IDX_W-1:0] hitIdx;
  logic             hit;

  // fixed-priority front end: lowest requester with a nonzero code wins
  always_comb begin
    winIdx   = '0;
    winFound = 1'b0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (reqValid[i] && (reqAction[i*ACT_W +: ACT_W] != '0)) begin
        winIdx   = IDX_W'(i);
        winFound = 1'b1;
      end
    end
  end

  // rotated priority search, excluding the requester (offset 0)
  always_comb begin
    hitIdx = '0;
    hit    = 1'b0;
    for (int k = NUM_CORES - 1; k >= 1; k--) begin
      int pos;
      pos = int'(winIdx) + k;
      if (pos >= NUM_CORES) pos = pos - NUM_CORES;
      if (eligible[pos]) begin
        hitIdx = IDX_W'(pos);
        hit    = 1'b1;
      end
    end
  end

  always_comb begin
    reqAccept = '0;
    if (winFound) reqAccept[winIdx] = 1'b1;
  end

  assign strb.reserve = winFound && hit;
  assign strb.anyReq  = winFound;
  assign resvIdx      = hitIdx;
  assign resvAct      = reqAction[winIdx*ACT_W +: ACT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantFound <= 1'b0;
      grantIdx   <= '1;
      grantReq   <= '0;
    end else begin
      grantValid <= winFound;
      grantFound <= winFound && hit;
      grantIdx   <= (winFound && hit) ? hitIdx : '1;
      grantReq   <= winIdx;
    end
  end

  AST_ACCEPT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqAccept)); // R8
  AST_NEVER_SELF: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantFound) |-> (grantIdx != grantReq)); // R3
  AST_GRANT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (|reqAccept) |=> grantValid); // R5
  AST_MISS_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !grantFound) |-> (grantIdx == '1)); // R6

endmodule

// File: rtl/core_resv_data.sv
module core_resv_data
  import core_resv_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int ACT_W     = 4,
  parameter int IDX_W     = $clog2(NUM_CORES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CORES-1:0]       inHost,
  input  logic [NUM_CORES-1:0]       doneValid,
  input  resvStrb_t                  strb,
  input  logic [IDX_W-1:0]           resvIdx,
  input  logic [ACT_W-1:0]           resvAct,
  output logic [NUM_CORES-1:0]       eligible,
  output logic [NUM_CORES*ACT_W-1:0] actionOut,
  output logic [NUM_CORES-1:0]       ownerValid
);

  logic [ACT_W-1:0]     actReg [NUM_CORES];
  logic [NUM_CORES-1:0] ownReg;
  logic [NUM_CORES-1:0] clrPend;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actReg[c]  <= '0;
        ownReg[c]  <= 1'b0;
        clrPend[c] <= 1'b0;
      end else begin
        if (clrPend[c]) begin
          actReg[c]  <= '0;
          clrPend[c] <= 1'b0;
        end else if (strb.reserve && (resvIdx == IDX_W'(c))) begin
          actReg[c] <= resvAct;
          ownReg[c] <= 1'b1;
        end
        if (doneValid[c] && ownReg[c]) begin
          ownReg[c]  <= 1'b0;
          clrPend[c] <= 1'b1;
        end
      end
    end

    assign eligible[c]                 = inHost[c] && (actReg[c] == '0);
    assign actionOut[c*ACT_W +: ACT_W] = actReg[c];
    assign ownerValid[c]               = ownReg[c];

    AST_OWNER_HAS_ACTION: assert property (@(posedge clk) disable iff (!rstN)
      ownReg[c] |-> (actReg[c] != '0)); // R5
    AST_OWNER_CLEARED_FIRST: assert property (@(posedge clk) disable iff (!rstN)
      clrPend[c] |-> !ownReg[c]); // R9
  end

  AST_RESERVE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strb.reserve |-> (actReg[resvIdx] == '0 && inHost[resvIdx] && resvAct != '0)); // R4
  AST_RESERVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    strb.reserve |-> strb.anyReq); // R7

endmodule

// File: rtl/core_resv_arbiter.sv
module core_resv_arbiter
  import core_resv_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int ACT_W     = 4,
  parameter int IDX_W     = $clog2(NUM_CORES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CORES-1:0]       inHost,
  input  logic [NUM_CORES-1:0]       reqValid,
  input  logic [NUM_CORES*ACT_W-1:0] reqAction,
  input  logic [NUM_CORES-1:0]       doneValid,
  output logic [NUM_CORES-1:0]       reqAccept,
  output logic                       grantValid,
  output logic                       grantFound,
  output logic [IDX_W-1:0]           grantIdx,
  output logic [IDX_W-1:0]           grantReq,
  output logic [NUM_CORES*ACT_W-1:0] actionOut,
  output logic [NUM_CORES-1:0]       ownerValid
);

  resvStrb_t            strb;
  logic [IDX_W-1:0]     resvIdx;
  logic [ACT_W-1:0]     resvAct;
  logic [NUM_CORES-1:0] eligible;

  core_resv_ctrl #(.NUM_CORES(NUM_CORES), .ACT_W(ACT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAction(reqAction),
    .eligible(eligible), .reqAccept(reqAccept), .strb(strb),
    .resvIdx(resvIdx), .resvAct(resvAct), .grantValid(grantValid),
    .grantFound(grantFound), .grantIdx(grantIdx), .grantReq(grantReq)
  );

  core_resv_data #(.NUM_CORES(NUM_CORES), .ACT_W(ACT_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .inHost(inHost), .doneValid(doneValid),
    .strb(strb), .resvIdx(resvIdx), .resvAct(resvAct), .eligible(eligible),
    .actionOut(actionOut), .ownerValid(ownerValid)
  );

endmodule

// File: tb/sim_core_resv_arbiter.sv
module sim_core_resv_arbiter;
  localparam int N = 8;
  localparam int A = 4;
  localparam int IW = $clog2(N);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] inHost = '0, reqValid = '0, doneValid = '0;
  logic [N*A-1:0] reqAction = '0;
  logic [N-1:0] reqAccept, ownerValid;
  logic grantValid, grantFound;
  logic [IW-1:0] grantIdx, grantReq;
  logic [N*A-1:0] actionOut;

  int checks = 0, errors = 0;
  int expAct [N];
  int expOwn [N];
  int expPend [N];
  int eWin, eHit, eIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_resv_arbiter #(.NUM_CORES(N), .ACT_W(A)) u0 (
    .clk(clk), .rstN(rstN), .inHost(inHost), .reqValid(reqValid),
    .reqAction(reqAction), .doneValid(doneValid), .reqAccept(reqAccept),
    .grantValid(grantValid), .grantFound(grantFound), .grantIdx(grantIdx),
    .grantReq(grantReq), .actionOut(actionOut), .ownerValid(ownerValid));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowestReq(input logic [N-1:0] rv, input logic [N*A-1:0] ra);
    for (int i = 0; i < N; i++)
      if (rv[i] && ra[i*A +: A] != 0) return i;
    return -1;
  endfunction

  function automatic int searchFrom(input int r, input logic [N-1:0] ih);
    for (int k = 1; k < N; k++) begin
      int p = (r + k) % N;
      if (ih[p] && expAct[p] == 0) return p;
    end
    return -1;
  endfunction

  task automatic checkState(input string tag);
    for (int c = 0; c < N; c++) begin
      chk(int'(actionOut[c*A +: A]) == expAct[c], {tag, " action"}, int'(actionOut[c*A +: A]), expAct[c]);
      chk(int'(ownerValid[c]) == expOwn[c], {tag, " owner"}, int'(ownerValid[c]), expOwn[c]);
    end
  endtask

  // one cycle: drive at negedge, check accept, model the edge, check at next negedge
  task automatic step(input logic [N-1:0] rv, input logic [N*A-1:0] ra,
                      input logic [N-1:0] ih, input logic [N-1:0] dn);
    logic [N-1:0] expAcc;
    reqValid = rv; reqAction = ra; inHost = ih; doneValid = dn;
    #1;
    eWin = lowestReq(rv, ra);
    expAcc = '0;
    if (eWin >= 0) expAcc[eWin] = 1'b1;
    chk(reqAccept == expAcc, "R8/R7 accept", int'(reqAccept), int'(expAcc));
    eIdx = (eWin >= 0) ? searchFrom(eWin, ih) : -1;
    eHit = (eIdx >= 0);
    @(posedge clk);
    for (int c = 0; c < N; c++) begin
      int ownOld = expOwn[c];
      if (expPend[c] != 0) begin
        expAct[c] = 0; expPend[c] = 0;
      end else if (eHit != 0 && eIdx == c) begin
        expAct[c] = int'(ra[eWin*A +: A]); expOwn[c] = 1;
      end
      if (dn[c] && ownOld != 0) begin
        expOwn[c] = 0; expPend[c] = 1;
      end
    end
    @(negedge clk);
    chk(grantValid == (eWin >= 0), "R7 grantValid", int'(grantValid), int'(eWin >= 0));
    if (eWin >= 0) begin
      chk(grantFound == eHit[0], "R6 grantFound", int'(grantFound), eHit);
      chk(int'(grantReq) == eWin, "R8 grantReq", int'(grantReq), eWin);
      if (eHit != 0) chk(int'(grantIdx) == eIdx, "R2 grantIdx", int'(grantIdx), eIdx);
      else chk(grantIdx == '1, "R6 miss index", int'(grantIdx), N - 1);
      if (eHit != 0) chk(int'(grantIdx) != eWin, "R3 not self", int'(grantIdx), eWin);
    end
    checkState("R5/R9 state");
    reqValid = '0; doneValid = '0;
  endtask

  function automatic logic [N*A-1:0] oneAct(input int core, input int code);
    logic [N*A-1:0] v = '0;
    v[core*A +: A] = A'(code);
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int c = 0; c < N; c++) begin expAct[c] = 0; expOwn[c] = 0; expPend[c] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(actionOut == '0, "R1 actions", int'(actionOut), 0);
    chk(ownerValid == '0, "R1 owners", int'(ownerValid), 0);
    chk(grantValid == 1'b0, "R1 grant", int'(grantValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: requester 2, all idle -> core 3
    step(8'h04, oneAct(2, 5), '1, '0);
    chk(int'(grantIdx) == 3, "R2 after requester", int'(grantIdx), 3);
    // R2 wrap: requester 7 -> core 0
    step(8'h80, oneAct(7, 3), '1, '0);
    chk(int'(grantIdx) == 0, "R2 wrap", int'(grantIdx), 0);
    // R4: busy core 3 skipped, host-off core 4 skipped -> core 5
    step(8'h04, oneAct(2, 6), 8'hEF, '0);
    chk(int'(grantIdx) == 5, "R4 skip busy", int'(grantIdx), 5);
    // R3/R6: only requester itself in host -> not found
    step(8'h02, oneAct(1, 7), 8'h02, '0);
    chk(grantFound == 1'b0, "R3 self only", int'(grantFound), 0);
    // R8: two requesters, lower wins
    step(8'h50, oneAct(4, 2) | oneAct(6, 9), '1, '0);
    chk(int'(grantReq) == 4, "R8 priority", int'(grantReq), 4);
    // R7: zero action code ignored
    step(8'h08, '0, '1, '0);
    chk(grantValid == 1'b0, "R7 zero code", int'(grantValid), 0);
    // R9: completion on core 3
    step('0, '0, '1, 8'h08);
    chk(ownerValid[3] == 1'b0 && actionOut[3*A +: A] != '0, "R9 owner first", int'(ownerValid[3]), 0);
    step('0, '0, '1, '0);
    chk(actionOut[3*A +: A] == '0, "R9 action cleared", int'(actionOut[3*A +: A]), 0);
    // R10: completion on unowned core 2
    step('0, '0, '1, 8'h04);
    chk(int'(actionOut[2*A +: A]) == expAct[2], "R10 ignored", int'(actionOut[2*A +: A]), expAct[2]);

    // constrained random
    for (int it = 0; it < 400; it++) begin
      logic [N-1:0] rv, ih, dn;
      logic [N*A-1:0] ra;
      rv = N'($urandom) & N'($urandom);
      ih = N'($urandom) | N'($urandom);
      dn = N'($urandom) & N'($urandom) & N'($urandom);
      ra = (N*A)'($urandom);
      step(rv, ra, ih, dn);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule